// File: doc/BRIEF.md
# Sync-Framed Serial Word Loader

This block turns a bit-serial stream into a parallel word for a frequency-offset register. A one-cycle pulse on the frame input marks the start of a word. The data bits then follow on consecutive clock cycles, most significant bit first. A 2-bit length code chooses how many bits form the word: 8, 16, 24 or 32. When the last bit of the chosen length arrives, the word goes into a 32-bit holding register, aligned to the top, and a one-cycle strobe reports the update.

A new frame pulse that comes before the current word is complete throws away the partial word and restarts framing. Between frames the data pin is ignored. A synchronous clear input forces the holding register to zero, so a consumer can run with no offset. An all-zero serial word has the same effect.

Top module: `serial_word_loader`

## Requirements
- R1: After reset, `hold_o` is zero and `load_done_o` is low.
- R2: A high on `sync_i` sampled at one rising edge makes the next consecutive rising edges sample data bits from `sdata_i`, most significant bit first. `hold_o` takes the assembled word at the edge that samples the final bit. `load_done_o` is high for exactly the one cycle that follows that edge, and it pulses exactly once for each completed word.
- R3: The length code on `width_sel_i` selects the word length: 2'b00 = 8 bits, 2'b01 = 16, 2'b10 = 24, 2'b11 = 32. The code is sampled at the same edge as the frame pulse, and later changes to it do not affect that frame.
- R4: A word shorter than 32 bits lands in the most significant bits of `hold_o`, and the remaining low bits are zero.
- R5: A high on `sync_i` during an unfinished frame discards the partial word and starts a new frame. This also applies when the pulse falls in the cycle where the final bit was due. No strobe or register update results from the discarded word.
- R6: Outside a frame, `sdata_i` has no effect: `hold_o` keeps its value and `load_done_o` stays low.
- R7: A high on `clear_i` zeroes `hold_o` at the next edge. If it coincides with the final bit of a word, the clear wins, `hold_o` becomes zero and no strobe is raised.
- R8: A frame pulse in the cycle right after a word's final bit is accepted as the start of the next word.
- R9: A serial word of all zeros loads zero into `hold_o` and still raises the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data, MSB first |
| sync_i | input | 1 | Frame pulse, one cycle before the first bit |
| width_sel_i | input | 2 | Word length code (8/16/24/32 bits) |
| clear_i | input | 1 | Synchronous zeroing of the holding register |
| hold_o | output | 32 | Holding register, word aligned to the top |
| load_done_o | output | 1 | One-cycle strobe on each holding-register update |

## Verification
The assertions check the following on every cycle: the strobe is never longer than one cycle; a frame pulse is never followed by a strobe; after a clear the register reads zero with no strobe; the register changes only on a strobe or after a clear; the low bits below each shorter length are zero; and the bit counter stays within the latched length. Only the bench scenarios can show the things that depend on the data stream itself: that the bits end up in the right order, that the length code is latched at the frame pulse, that aborted and back-to-back frames produce exactly the expected sequence of words, and that idle data is ignored.

// File: rtl/swl_pkg.sv
package swl_pkg;

   // Number of bits in the frame selected by a length code.
   function automatic int unsigned frame_bits(input int unsigned sel,
                                              input int unsigned step);
      return (sel + 1) * step;
   endfunction

endpackage

// File: rtl/swl_frame_ctrl.sv
module swl_frame_ctrl #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned STEP_W = 8,
   parameter int unsigned SEL_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             bit_en_o,
   output logic             last_o,
   output logic [SEL_W-1:0] sel_q_o
);
   import swl_pkg::*;

   localparam int unsigned NUM_W = 1 << SEL_W;
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] last_idx_tbl [NUM_W];
   logic [CNT_W-1:0] last_idx;

   // Final bit index for each length code, built per code.
   for (genvar g = 0; g < NUM_W; g++) begin : g_len
      assign last_idx_tbl[g] = CNT_W'(frame_bits(g, STEP_W) - 1);
   end

   assign last_idx = last_idx_tbl[sel_q];

   // A frame pulse takes priority over a data bit in the same cycle.
   assign bit_en_o = active_q && !sync_i;
   assign last_o   = bit_en_o && (cnt_q == last_idx);
   assign sel_q_o  = sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sel_q    <= '0;
      end else if (sync_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         sel_q    <= sel_i;
      end else if (active_q) begin
         if (cnt_q == last_idx) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R3: the bit counter never runs past the latched length
   assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q <= last_idx));

   // R6: the counter rests at zero between frames
   assert_idle_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (cnt_q == '0));

endmodule

// File: rtl/swl_shift_in.sv
module swl_shift_in #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              shift_en_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] next_word_o
);
   logic [WORD_W-1:0] shreg_q;

   // Word including the bit present this cycle, newest bit lowest.
   assign next_word_o = {shreg_q[WORD_W-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
      end else if (start_i) begin
         shreg_q <= '0;
      end else if (shift_en_i) begin
         shreg_q <= next_word_o;
      end
   end

   // R5: a frame pulse leaves no trace of the discarded partial word
   assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (shreg_q == '0));

endmodule

// File: rtl/swl_align.sv
module swl_align #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned STEP_W = 8,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [WORD_W-1:0] word_o
);
   import swl_pkg::*;

   localparam int unsigned NUM_W = 1 << SEL_W;

   logic [WORD_W-1:0] cand [NUM_W];

   // One top-aligned candidate per length; the short ones are zero-padded.
   for (genvar g = 0; g < NUM_W; g++) begin : g_cand
      localparam int unsigned LEN = frame_bits(g, STEP_W);
      if (LEN >= WORD_W) begin : g_full
         assign cand[g] = word_i;
      end else begin : g_short
         assign cand[g] = {word_i[LEN-1:0], {(WORD_W-LEN){1'b0}}};
      end
   end

   assign word_o = cand[sel_i];

endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned STEP_W = 8,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdata_i,
   input  logic              sync_i,
   input  logic [SEL_W-1:0]  width_sel_i,
   input  logic              clear_i,
   output logic [WORD_W-1:0] hold_o,
   output logic              load_done_o
);
   import swl_pkg::*;

   localparam int unsigned NUM_W = 1 << SEL_W;

   // Elaboration-time parameter checks.
   if (STEP_W == 0 || (WORD_W % STEP_W) != 0) begin : g_bad_step
      $error("serial_word_loader: WORD_W must be a multiple of STEP_W");
   end
   if ((WORD_W / STEP_W) != NUM_W) begin : g_bad_sel
      $error("serial_word_loader: SEL_W must encode exactly WORD_W/STEP_W lengths");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("serial_word_loader: WORD_W must be at least 2");
   end

   logic              bit_en;
   logic              last_bit;
   logic [SEL_W-1:0]  sel_q;
   logic [WORD_W-1:0] raw_word;
   logic [WORD_W-1:0] aligned;
   logic [WORD_W-1:0] hold_q;
   logic              done_q;

   swl_frame_ctrl #(
      .WORD_W (WORD_W),
      .STEP_W (STEP_W),
      .SEL_W  (SEL_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_i),
      .sel_i    (width_sel_i),
      .bit_en_o (bit_en),
      .last_o   (last_bit),
      .sel_q_o  (sel_q)
   );

   swl_shift_in #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (sync_i),
      .shift_en_i  (bit_en),
      .bit_i       (sdata_i),
      .next_word_o (raw_word)
   );

   swl_align #(
      .WORD_W (WORD_W),
      .STEP_W (STEP_W),
      .SEL_W  (SEL_W)
   ) u_align (
      .word_i (raw_word),
      .sel_i  (sel_q),
      .word_o (aligned)
   );

   // Holding register: clear has priority over a completing word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last_bit && !clear_i;
         if (clear_i) begin
            hold_q <= '0;
         end else if (last_bit) begin
            hold_q <= aligned;
         end
      end
   end

   assign hold_o      = hold_q;
   assign load_done_o = done_q;

   // R2: the strobe lasts a single cycle
   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_done_o |=> !load_done_o);

   // R5: a frame pulse never completes a word at the same edge
   assert_sync_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> !load_done_o);

   // R7: clear zeroes the register and suppresses the strobe
   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (hold_o == '0) && !load_done_o);

   // R6: the register moves only on a strobe or after a clear
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_done_o && !$past(clear_i)) |-> $stable(hold_o));

   // R4: bits below a short word are zero
   for (genvar g = 0; g < NUM_W - 1; g++) begin : g_pad_chk
      localparam int unsigned LEN = frame_bits(g, STEP_W);
      assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (load_done_o && (sel_q == SEL_W'(g))) |-> (hold_o[WORD_W-LEN-1:0] == '0));
   end

endmodule

// File: tb/serial_word_loader_tb.sv
`timescale 1ns/1ps
module serial_word_loader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdata_i = 1'b0;
   logic        sync_i = 1'b0;
   logic [1:0]  width_sel_i = 2'b00;
   logic        clear_i = 1'b0;
   logic [31:0] hold_o;
   logic        load_done_o;

   int          n_checks = 0;
   int          n_fail = 0;
   int          cycles = 0;
   logic [31:0] exp_q [$];
   logic [31:0] last_loaded = 32'h0;

   always #2.5 clk = ~clk;

   serial_word_loader u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sdata_i     (sdata_i),
      .sync_i      (sync_i),
      .width_sel_i (width_sel_i),
      .clear_i     (clear_i),
      .hold_o      (hold_o),
      .load_done_o (load_done_o)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Monitor: every strobe must match the oldest expected word (R2).
   always @(negedge clk) begin
      if (rst_n && load_done_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected strobe", hold_o, last_loaded);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(hold_o == e, "R2/R3/R4 loaded word", hold_o, e);
            last_loaded = hold_o;
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected <100000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // Driver: frame pulse, then nbits data bits MSB first. The length code
   // is inverted after the pulse to show it is latched (R3).
   task automatic send_frame(input logic [1:0] sel, input logic [31:0] val,
                             input int nbits, input bit expect_load,
                             input bit clr_on_last);
      int len;
      len = (int'(sel) + 1) * 8;
      @(negedge clk);
      sync_i = 1'b1;
      width_sel_i = sel;
      sdata_i = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         sync_i = 1'b0;
         width_sel_i = ~sel;
         sdata_i = val[len-1-i];
         if (i == nbits - 1) begin
            if (clr_on_last) clear_i = 1'b1;
            if (expect_load) exp_q.push_back(val << (32 - len));
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sync_i = 1'b0;
         clear_i = 1'b0;
         sdata_i = i[0] ^ i[2];
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(hold_o == 32'h0, "R1 reset hold", hold_o, 32'h0);
      check(load_done_o == 1'b0, "R1 reset strobe", {31'h0, load_done_o}, 32'h0);
      rst_n = 1'b1;
      idle(2);

      send_frame(2'b11, 32'hA5C3_1E7F, 32, 1'b1, 1'b0);   // R2 R3 32-bit
      idle(3);
      send_frame(2'b00, 32'h0000_0096, 8, 1'b1, 1'b0);    // R3 R4 8-bit
      idle(2);
      send_frame(2'b01, 32'h0000_BEEF, 16, 1'b1, 1'b0);   // R4 16-bit
      idle(2);
      send_frame(2'b10, 32'h0013_579B, 24, 1'b1, 1'b0);   // R4 24-bit
      idle(2);
      // R8: back-to-back frames
      send_frame(2'b00, 32'h0000_0001, 8, 1'b1, 1'b0);
      send_frame(2'b11, 32'h8000_0001, 32, 1'b1, 1'b0);
      idle(2);
      // R5: abort mid-word, then restart
      send_frame(2'b11, 32'hFFFF_FFFF, 10, 1'b0, 1'b0);
      send_frame(2'b01, 32'h0000_1234, 16, 1'b1, 1'b0);
      idle(2);
      // R5: pulse lands where the final bit was due
      send_frame(2'b00, 32'h0000_00FF, 7, 1'b0, 1'b0);
      send_frame(2'b00, 32'h0000_003C, 8, 1'b1, 1'b0);
      idle(2);
      // R6: toggling data while idle has no effect
      idle(20);
      check(hold_o == 32'h3C00_0000, "R6 idle hold kept", hold_o, 32'h3C00_0000);
      // R9: all-zero word
      send_frame(2'b11, 32'h0000_0000, 32, 1'b1, 1'b0);
      idle(2);
      check(hold_o == 32'h0, "R9 zero word", hold_o, 32'h0);
      send_frame(2'b10, 32'h00FF_FFFF, 24, 1'b1, 1'b0);   // R4 padding
      idle(2);
      // R7: plain clear
      @(negedge clk); clear_i = 1'b1;
      @(negedge clk); clear_i = 1'b0;
      check(hold_o == 32'h0, "R7 clear", hold_o, 32'h0);
      send_frame(2'b01, 32'h0000_ABCD, 16, 1'b1, 1'b0);
      idle(2);
      // R7: clear coinciding with final bit wins, no strobe
      send_frame(2'b01, 32'h0000_FFFF, 16, 1'b0, 1'b1);
      @(negedge clk); clear_i = 1'b0;
      check(hold_o == 32'h0, "R7 clear beats load", hold_o, 32'h0);
      check(load_done_o == 1'b0, "R7 no strobe on clear", {31'h0, load_done_o}, 32'h0);
      idle(5);
      check(exp_q.size() == 0, "R2 every word strobed", exp_q.size(), 32'h0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule